// File: doc/BRIEF.md
# Segment Selector Translation Unit

This block turns a logical reference into a linear address. A reference is a 16-bit selector plus a 32-bit offset. The selector names one entry in one of two descriptor tables held in memory. One table is global and one is local, and each has its own base register. The unit works out where the 8-byte descriptor sits. It reads the descriptor from memory as two 32-bit words over a simple request and response port. It then compares the offset with the segment limit. A legal offset yields the segment base plus the offset. An offset that is too large raises an addressing fault and yields no address.

A request is offered with a one-cycle `req_valid` pulse while the unit is idle. The result appears with a one-cycle `done` pulse. In the same cycle `fault` goes high if the reference was illegal. The requested privilege field of the selector is only decoded and passed out. Privilege checks, descriptor caching and paging lie outside this unit.

The descriptor layout is deliberately simple. The word at the lower address holds the 32-bit base. The word four bytes above it holds the 32-bit limit.

Top module: `seg_xlate_unit`

## Requirements
- R1: While reset is high, and in the cycle after it, `done`, `fault` and `mem_rd` are low and `lin_addr` is zero.
- R2: The selector fields are laid out as follows. Bits [15:3] are the descriptor index. Bit 2 chooses the table: 0 selects `gtab_base` and 1 selects `ltab_base`. Bits [1:0] are the requested privilege level.
- R3: The descriptor address is the chosen table base plus eight times the index, taken modulo 2^32.
- R4: Each request makes exactly two memory reads, each a one-cycle `mem_rd` pulse. The first read is at the descriptor address and returns the base. The second read is at the descriptor address plus 4 and returns the limit. The second read is issued only after `mem_rvalid` has answered the first.
- R5: When the offset is strictly below the limit, `done` pulses with `fault` low. In that cycle `lin_addr` equals base plus offset, taken modulo 2^32.
- R6: When the offset is greater than or equal to the limit, `done` and `fault` are both high for one cycle and `lin_addr` is zero.
- R7: In the cycle `done` is high, `rpl_out` equals bits [1:0] of the selector of that request.
- R8: A `req_valid` that arrives while a request is in progress is ignored. It causes no extra memory read, no extra `done`, and no change to the result of the request in progress.
- R9: `done` never stays high for two cycles in a row, and `fault` is never high without `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle request strobe, taken only when idle |
| req_sel | input | 16 | Selector of the logical reference |
| req_off | input | 32 | Offset of the logical reference |
| gtab_base | input | 32 | Base address of the global descriptor table |
| ltab_base | input | 32 | Base address of the local descriptor table |
| mem_rd | output | 1 | One-cycle memory read request |
| mem_addr | output | 32 | Byte address of the word being read |
| mem_rvalid | input | 1 | Read data valid strobe |
| mem_rdata | input | 32 | Read data word |
| lin_addr | output | 32 | Linear address, valid with done when fault is low |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Addressing fault, high only together with done |
| rpl_out | output | 2 | Requested privilege level of the completed request |

## Verification
A wrongly decoded index or table bit first shows on `mem_addr`, on the very first read pulse, several cycles before `done`. A fetch sequencer that has lost its place shows up as a missing, doubled or misplaced second read, or as a `done` that never comes. The bench catches a hung unit with its per-request timeout. A stale captured base, limit or offset shows only at `done`: as a wrong `lin_addr`, or as `fault` on the wrong side of the limit. For this reason the sweep steps offsets around each limit: one below it, equal to it, and one above it.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    localparam int SEL_W      = 16;
    localparam int ADDR_W     = 32;
    localparam int IDX_W      = 13;
    localparam int RPL_W      = 2;
    localparam int DESC_BYTES = 8;
    localparam int WORD_BYTES = 4;
    localparam int DESC_SHIFT = $clog2(DESC_BYTES);
    localparam int PAD_W      = ADDR_W - IDX_W - DESC_SHIFT;

    typedef struct packed {
        logic [IDX_W-1:0] index;
        logic             ti;
        logic [RPL_W-1:0] rpl;
    } sel_t;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] limit;
    } desc_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_BASE,
        ST_WT_BASE,
        ST_RD_LIM,
        ST_WT_LIM,
        ST_CHECK
    } fetch_st_e;

    function automatic logic [ADDR_W-1:0] desc_addr(
        input logic [ADDR_W-1:0] tbase,
        input logic [IDX_W-1:0]  index
    );
        logic [ADDR_W-1:0] scaled;
        scaled = {{PAD_W{1'b0}}, index, {DESC_SHIFT{1'b0}}};
        return tbase + scaled;
    endfunction

    function automatic logic offset_legal(
        input logic [ADDR_W-1:0] off,
        input logic [ADDR_W-1:0] limit
    );
        return off < limit;
    endfunction

endpackage

// File: rtl/seg_sel_decode.sv
module seg_sel_decode
    import seg_xlate_pkg::*;
(
    input  logic [SEL_W-1:0]  sel_raw,
    input  logic [ADDR_W-1:0] gtab_base,
    input  logic [ADDR_W-1:0] ltab_base,
    output logic [ADDR_W-1:0] daddr,
    output logic [RPL_W-1:0]  rpl
);
    sel_t              sel;
    logic [ADDR_W-1:0] tbase;

    always_comb begin
        sel   = sel_t'(sel_raw);
        tbase = sel.ti ? ltab_base : gtab_base;
        daddr = desc_addr(tbase, sel.index);
        rpl   = sel.rpl;
    end
endmodule

// File: rtl/seg_desc_fetch.sv
module seg_desc_fetch
    import seg_xlate_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] daddr,
    output logic              busy,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [ADDR_W-1:0] mem_rdata,
    output logic              words_ready,
    output desc_t             desc
);
    localparam logic [ADDR_W-1:0] LIM_STEP = ADDR_W'(WORD_BYTES);

    fetch_st_e         st_q, st_d;
    logic [ADDR_W-1:0] addr_q;
    desc_t             desc_q;

    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE:    if (start) st_d = ST_RD_BASE;
            ST_RD_BASE: st_d = ST_WT_BASE;
            ST_WT_BASE: if (mem_rvalid) st_d = ST_RD_LIM;
            ST_RD_LIM:  st_d = ST_WT_LIM;
            ST_WT_LIM:  if (mem_rvalid) st_d = ST_CHECK;
            ST_CHECK:   st_d = ST_IDLE;
            default:    st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            addr_q <= '0;
            desc_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_IDLE && start) begin
                addr_q <= daddr;
            end
            if (st_q == ST_WT_BASE && mem_rvalid) begin
                desc_q.base <= mem_rdata;
            end
            if (st_q == ST_WT_LIM && mem_rvalid) begin
                desc_q.limit <= mem_rdata;
            end
        end
    end

    always_comb begin
        busy        = (st_q != ST_IDLE);
        mem_rd      = (st_q == ST_RD_BASE) || (st_q == ST_RD_LIM);
        mem_addr    = (st_q == ST_RD_LIM) ? addr_q + LIM_STEP : addr_q;
        words_ready = (st_q == ST_CHECK);
        desc        = desc_q;
    end
endmodule

// File: rtl/seg_limit_check.sv
module seg_limit_check
    import seg_xlate_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  logic [ADDR_W-1:0] off,
    input  desc_t             desc,
    input  logic [RPL_W-1:0]  rpl_in,
    output logic [ADDR_W-1:0] lin_addr,
    output logic              done,
    output logic              fault,
    output logic [RPL_W-1:0]  rpl_out
);
    logic              legal;
    logic [ADDR_W-1:0] sum;

    always_comb begin
        legal = offset_legal(off, desc.limit);
        sum   = desc.base + off;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lin_addr <= '0;
            done     <= 1'b0;
            fault    <= 1'b0;
            rpl_out  <= '0;
        end else begin
            done  <= fire;
            fault <= fire && !legal;
            if (fire) begin
                lin_addr <= legal ? sum : '0;
                rpl_out  <= rpl_in;
            end
        end
    end
endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
    import seg_xlate_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [SEL_W-1:0]  req_sel,
    input  logic [ADDR_W-1:0] req_off,
    input  logic [ADDR_W-1:0] gtab_base,
    input  logic [ADDR_W-1:0] ltab_base,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [ADDR_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] lin_addr,
    output logic              done,
    output logic              fault,
    output logic [RPL_W-1:0]  rpl_out
);
    logic [ADDR_W-1:0] daddr;
    logic [RPL_W-1:0]  rpl_dec;
    logic              busy;
    logic              accept;
    logic              words_ready;
    desc_t             desc;
    logic [ADDR_W-1:0] off_q;
    logic [RPL_W-1:0]  rpl_q;

    seg_sel_decode i_dec (
        .sel_raw   (req_sel),
        .gtab_base (gtab_base),
        .ltab_base (ltab_base),
        .daddr     (daddr),
        .rpl       (rpl_dec)
    );

    assign accept = req_valid && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            off_q <= '0;
            rpl_q <= '0;
        end else if (accept) begin
            off_q <= req_off;
            rpl_q <= rpl_dec;
        end
    end

    seg_desc_fetch i_fetch (
        .clk         (clk),
        .rst         (rst),
        .start       (accept),
        .daddr       (daddr),
        .busy        (busy),
        .mem_rd      (mem_rd),
        .mem_addr    (mem_addr),
        .mem_rvalid  (mem_rvalid),
        .mem_rdata   (mem_rdata),
        .words_ready (words_ready),
        .desc        (desc)
    );

    seg_limit_check i_chk_lim (
        .clk      (clk),
        .rst      (rst),
        .fire     (words_ready),
        .off      (off_q),
        .desc     (desc),
        .rpl_in   (rpl_q),
        .lin_addr (lin_addr),
        .done     (done),
        .fault    (fault),
        .rpl_out  (rpl_out)
    );
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk
    import seg_xlate_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              mem_rd,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [ADDR_W-1:0] lin_addr,
    input logic              done,
    input logic              fault
);
    logic              rd_par;
    logic [ADDR_W-1:0] last_rd_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_par       <= 1'b0;
            last_rd_addr <= '0;
        end else if (mem_rd) begin
            rd_par       <= !rd_par;
            last_rd_addr <= mem_addr;
        end
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!done && !fault && !mem_rd && lin_addr == '0));

    p_rd_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> !mem_rd);

    p_lim_word_addr_r4: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && rd_par) |-> (mem_addr == last_rd_addr + ADDR_W'(WORD_BYTES)));

    p_done_pairs_reads_r4: assert property (@(posedge clk) disable iff (rst)
        done |-> (!rd_par && !mem_rd));

    p_fault_no_addr_r6: assert property (@(posedge clk) disable iff (rst)
        fault |-> (lin_addr == '0));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_fault_with_done_r9: assert property (@(posedge clk) disable iff (rst)
        fault |-> done);
endmodule

bind seg_xlate_unit seg_xlate_chk i_xlate_chk (
    .clk      (clk),
    .rst      (rst),
    .mem_rd   (mem_rd),
    .mem_addr (mem_addr),
    .lin_addr (lin_addr),
    .done     (done),
    .fault    (fault)
);

// File: tb/test_seg_xlate_unit.sv
`timescale 1ns/1ps
module test_seg_xlate_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [15:0] req_sel = '0;
    logic [31:0] req_off = '0;
    logic [31:0] gtab_base = 32'h0000_8000;
    logic [31:0] ltab_base = 32'h0004_0000;
    logic        mem_rd;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [31:0] lin_addr;
    logic        done;
    logic        fault;
    logic [1:0]  rpl_out;

    int n_chk = 0;
    int n_fail = 0;
    int mem_lat = 0;
    int rd_n = 0;
    logic [31:0] rd_addr [0:3];

    always #5 clk = !clk;

    seg_xlate_unit i_seg_xlate_unit (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_sel(req_sel),
        .req_off(req_off), .gtab_base(gtab_base), .ltab_base(ltab_base),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .lin_addr(lin_addr), .done(done),
        .fault(fault), .rpl_out(rpl_out)
    );

    function automatic logic [31:0] d_base(input logic [31:0] da);
        if (da == 32'h0000_8010) return 32'd4300;
        if (da == 32'h0000_8018) return 32'hFFFF_FFF0;
        return (da * 32'd7) ^ 32'h1234_0000;
    endfunction

    function automatic logic [31:0] d_limit(input logic [31:0] da);
        if (da == 32'h0000_8010) return 32'd1000;
        if (da == 32'h0000_8018) return 32'h0000_0100;
        return ((da >> 3) & 32'd15) * 32'd4 + 32'd2;
    endfunction

    function automatic logic [31:0] mword(input logic [31:0] a);
        logic [31:0] da;
        da = {a[31:3], 3'b000};
        return a[2] ? d_limit(da) : d_base(da);
    endfunction

    task automatic chk(input logic ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // memory responder
    initial begin
        @(negedge clk);
        forever begin
            if (mem_rd === 1'b1) begin
                logic [31:0] a;
                a = mem_addr;
                if (rd_n < 4) rd_addr[rd_n] = a;
                rd_n++;
                repeat (mem_lat + 1) @(negedge clk);
                mem_rvalid = 1'b1;
                mem_rdata  = mword(a);
                @(negedge clk);
                mem_rvalid = 1'b0;
            end else begin
                @(negedge clk);
            end
        end
    end

    task automatic wait_done(output logic seen);
        seen = 1'b0;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (done) begin
                seen = 1'b1;
                break;
            end
        end
    endtask

    task automatic run_tx(input logic ti, input logic [12:0] idx,
                          input logic [1:0] rpl, input logic [31:0] off,
                          input logic [31:0] gb, input logic [31:0] lb);
        logic [31:0] da, eb, el, elin;
        logic        ef, seen;
        da   = (ti ? lb : gb) + {16'd0, idx, 3'b000};
        eb   = d_base(da);
        el   = d_limit(da);
        ef   = !(off < el);
        elin = ef ? 32'd0 : eb + off;
        gtab_base = gb;
        ltab_base = lb;
        rd_n = 0;
        @(negedge clk);
        req_sel   = {idx, ti, rpl};
        req_off   = off;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        wait_done(seen);
        chk(seen, "R5/R6 done seen", {31'd0, seen}, 32'd1);
        chk(fault == ef, ef ? "R6 fault on offset>=limit" : "R5 no fault below limit",
            {31'd0, fault}, {31'd0, ef});
        chk(lin_addr == elin, ef ? "R6 lin_addr zero" : "R5 lin_addr base+offset",
            lin_addr, elin);
        chk(rpl_out == rpl, "R7 rpl passthrough", {30'd0, rpl_out}, {30'd0, rpl});
        chk(rd_n == 2, "R4 two reads", rd_n, 32'd2);
        chk(rd_addr[0] == da, "R2 R3 descriptor address", rd_addr[0], da);
        chk(rd_addr[1] == da + 32'd4, "R4 limit word address", rd_addr[1], da + 32'd4);
        @(negedge clk);
        chk(!done && !fault, "R9 single-cycle done", {30'd0, done, fault}, 32'd0);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [12:0] idx_list [0:3];
        logic [31:0] lim;
        logic        seen;
        idx_list[0] = 13'd0;
        idx_list[1] = 13'd1;
        idx_list[2] = 13'd5;
        idx_list[3] = 13'd8191;

        repeat (3) @(negedge clk);
        chk(!done && !fault && !mem_rd && lin_addr == 0, "R1 outputs in reset",
            {29'd0, done, fault, mem_rd}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(!done && !fault && !mem_rd && lin_addr == 0, "R1 outputs after reset",
            lin_addr, 32'd0);

        // R5 R6 worked example: base 4300 limit 1000
        run_tx(1'b0, 13'd2, 2'd1, 32'd53,   32'h0000_8000, 32'h0004_0000);
        chk(lin_addr == 32'd4353, "R5 example 4300+53", lin_addr, 32'd4353);
        run_tx(1'b0, 13'd2, 2'd2, 32'd1222, 32'h0000_8000, 32'h0004_0000);
        run_tx(1'b0, 13'd2, 2'd3, 32'd1000, 32'h0000_8000, 32'h0004_0000);
        run_tx(1'b0, 13'd2, 2'd0, 32'd999,  32'h0000_8000, 32'h0004_0000);
        // R5 base+offset wraps modulo 2^32
        run_tx(1'b0, 13'd3, 2'd1, 32'h20,   32'h0000_8000, 32'h0004_0000);
        // R3 table base + index*8 wraps
        run_tx(1'b1, 13'd8191, 2'd2, 32'd0, 32'h0000_8000, 32'hFFFF_FFF0);

        // sweep: table bit, index, offsets around the limit, latencies
        for (int t = 0; t < 2; t++) begin
            for (int i = 0; i < 4; i++) begin
                for (int o = 0; o < 5; o++) begin
                    logic [31:0] da;
                    logic [31:0] off;
                    da  = (t != 0 ? 32'h0004_0000 : 32'h0000_8000) + {16'd0, idx_list[i], 3'b000};
                    lim = d_limit(da);
                    case (o)
                        0: off = 32'd0;
                        1: off = lim - 32'd1;
                        2: off = lim;
                        3: off = lim + 32'd1;
                        default: off = 32'hFFFF_FFFF;
                    endcase
                    mem_lat = (t * 20 + i * 5 + o) % 3;
                    run_tx(t[0], idx_list[i], 2'(i + o), off,
                           32'h0000_8000, 32'h0004_0000);
                end
            end
        end

        // R8: second request while busy is ignored
        mem_lat = 2;
        rd_n = 0;
        gtab_base = 32'h0000_8000;
        @(negedge clk);
        req_sel = {13'd2, 1'b0, 2'd3};
        req_off = 32'd53;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        req_sel = {13'd7, 1'b1, 2'd1};
        req_off = 32'd0;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        wait_done(seen);
        chk(seen && !fault && lin_addr == 32'd4353, "R8 first request result kept",
            lin_addr, 32'd4353);
        chk(rpl_out == 2'd3, "R8 first request rpl kept", {30'd0, rpl_out}, 32'd3);
        seen = 1'b0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (done) seen = 1'b1;
        end
        chk(!seen, "R8 no extra done", {31'd0, seen}, 32'd0);
        chk(rd_n == 2, "R8 no extra reads", rd_n, 32'd2);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule